// File: doc/BRIEF.md
# Timeslot Serial Audio Capture Byte Packer

This block receives a serial audio stream from an external converter that is the bus master. The converter drives the bit clock and the word-select line. The block drives neither of them. It oversamples the bit clock, word-select and serial data with the system clock, then takes one data bit on each rising edge of the bit clock.

Each frame has 64 bit clocks. The frame is divided into 8 timeslots of 8 bits each, and every timeslot carries one byte, MSB first. A rising edge on word-select puts the slot counter back to slot 0. A per-slot enable mask decides which slots keep their byte.

Kept bytes are packed into a 4-byte word through a place pointer. That pointer is never tied to frame boundaries: it wraps after every fourth stored byte. A swap input chooses whether the first byte of a word goes to the top or the bottom byte lane. Each completed word is offered to a downstream FIFO with a one-cycle valid strobe. If the FIFO is not ready at that moment, the word is dropped and a sticky overflow flag is set.

Top module: `i2s_slot_packer`

## Requirements
- R1: A frame is 64 bit-clock periods split into 8 slots of 8 bits. Bits are taken on bit-clock rising edges, MSB first. The bit sampled on the same rising edge where word-select is first seen high is bit 7 of slot 0.
- R2: A word-select rising edge restarts the slot count at slot 0, even in the middle of a frame. Bytes from slots that completed before the edge are kept, and the partial slot is discarded.
- R3: Before the first word-select rising edge after reset, no byte is stored and no word is produced.
- R4: Slot s stores its byte only when bit s of the slot enable mask is 1. A disabled slot leaves the word buffer and the place pointer unchanged.
- R5: The place pointer is not reset by frame ends or by word-select edges. It wraps after 4 stored bytes, so one word may span several frames.
- R6: With swap at 0, the first byte of a word lands in bits 31:24, and later bytes go to bits 23:16, 15:8 and 7:0 in turn.
- R7: With swap at 1, the first byte of a word lands in bits 7:0, and later bytes go to bits 15:8, 23:16 and 31:24 in turn.
- R8: Storing the fourth byte of a word while the FIFO is ready puts the word on word_o with word_valid_o high for exactly one system clock cycle.
- R9: Storing the fourth byte while the FIFO is not ready drops that word without a valid strobe and sets overflow_o. overflow_o then stays at 1 until reset.
- R10: While reset is applied and after it is released, word_valid_o, word_o and overflow_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, must be at least 6x the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Bit clock from the converter |
| ws_i | input | 1 | Word-select from the converter |
| sd_i | input | 1 | Serial data from the converter |
| slot_en_i | input | 8 | Per-slot store enable, bit s for slot s |
| swap_i | input | 1 | Byte lane order: 0 first byte high, 1 first byte low |
| fifo_rdy_i | input | 1 | Downstream FIFO can accept a word |
| word_o | output | 32 | Packed word |
| word_valid_o | output | 1 | One-cycle strobe for word_o |
| overflow_o | output | 1 | Sticky flag: a word was dropped |

## Verification
The hardest state to reach from the ports is a place pointer that is not aligned to a frame or slot boundary while word-select resynchronises the slot counter. The stimulus builds it up on purpose in three ways:
- Frames whose masks store only two bytes, so a word spans two frames.
- A truncated 40-bit frame that stores five bytes and is then cut short by a fresh word-select rise.
- A frame sent with the FIFO stalled, whose dropped words start one byte into the word.

A running byte-level model in the bench follows the pointer through all of these cases, so every later word checks that it was carried over correctly.

// File: rtl/i2s_slot_packer_pkg.sv
package i2s_slot_packer_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // lane a byte lands in, given its position within the word
  function automatic int unsigned lane_of(input int unsigned place, input logic swap,
                                          input int unsigned nbytes);
    return swap ? place : (nbytes - 1 - place);
  endfunction
endpackage

// File: rtl/i2s_slot_packer_sync.sv
module i2s_slot_packer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic sck_rise_o,
  output logic ws_o,
  output logic sd_o
);
  logic [STAGES-1:0] sck_q, ws_q, sd_q;
  logic              sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= '0;
      ws_q    <= '0;
      sd_q    <= '0;
      sck_d_q <= 1'b0;
    end else begin
      sck_q   <= {sck_q[STAGES-2:0], sck_i};
      ws_q    <= {ws_q[STAGES-2:0], ws_i};
      sd_q    <= {sd_q[STAGES-2:0], sd_i};
      sck_d_q <= sck_q[STAGES-1];
    end
  end

  assign sck_rise_o = sck_q[STAGES-1] & ~sck_d_q;
  assign ws_o       = ws_q[STAGES-1];
  assign sd_o       = sd_q[STAGES-1];

  // R1
  sck_rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_o |=> !sck_rise_o);
endmodule

// File: rtl/i2s_slot_packer_slot_seq.sv
module i2s_slot_packer_slot_seq
  import i2s_slot_packer_pkg::*;
#(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned SLOT_BITS = 8,
  localparam int unsigned FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
  localparam int unsigned SUB_W      = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              byte_vld_o,
  output byte_t             byte_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [CNT_W-1:0] bit_cnt_q, cur;
  logic             ws_prev_q, locked_q, ws_rise, lock_now;
  byte_t            shift_q, shift_nxt;

  assign ws_rise   = ws_i & ~ws_prev_q;
  assign cur       = ws_rise ? '0 : bit_cnt_q;
  assign lock_now  = locked_q | ws_rise;
  assign shift_nxt = {shift_q[BYTE_W-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      ws_prev_q  <= 1'b0;
      locked_q   <= 1'b0;
      shift_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      slot_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (sck_rise_i) begin
        ws_prev_q <= ws_i;
        locked_q  <= lock_now;
        shift_q   <= shift_nxt;
        bit_cnt_q <= (cur == CNT_W'(FRAME_BITS - 1)) ? '0 : cur + 1'b1;
        if (lock_now && cur[SUB_W-1:0] == SUB_W'(SLOT_BITS - 1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= shift_nxt;
          slot_o     <= cur[CNT_W-1:SUB_W];
        end
      end
    end
  end

  // R3
  no_byte_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> locked_q);
  // R1
  byte_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/i2s_slot_packer_packer.sv
module i2s_slot_packer_packer
  import i2s_slot_packer_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned PTR_W  = $clog2(BYTES),
  localparam int unsigned WORD_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  byte_t             byte_i,
  input  logic              swap_i,
  input  logic              fifo_rdy_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              overflow_o
);
  logic [BYTES-1:0][BYTE_W-1:0] buf_q, buf_nxt;
  logic [PTR_W-1:0]             place_q;
  logic                         last;

  assign last = (place_q == PTR_W'(BYTES - 1));

  always_comb begin
    buf_nxt = buf_q;
    buf_nxt[lane_of(32'(place_q), swap_i, BYTES)] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q        <= '0;
      place_q      <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      overflow_o   <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (store_i) begin
        buf_q   <= buf_nxt;
        place_q <= last ? '0 : place_q + 1'b1;
        if (last) begin
          if (fifo_rdy_i) begin
            word_o       <= buf_nxt;
            word_valid_o <= 1'b1;
          end else begin
            overflow_o <= 1'b1;
          end
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);
  // R9
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R9
  no_valid_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !fifo_rdy_i) |=> !word_valid_o);
  // R4
  place_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> $stable(place_q));
endmodule

// File: rtl/i2s_slot_packer.sv
module i2s_slot_packer
  import i2s_slot_packer_pkg::*;
#(
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned SLOT_BITS   = 8,
  parameter int unsigned BYTES       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned WORD_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [SLOTS-1:0]  slot_en_i,
  input  logic              swap_i,
  input  logic              fifo_rdy_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              overflow_o
);
  logic              sck_rise, ws_s, sd_s, byte_vld, store;
  byte_t             byte_val;
  logic [SLOT_W-1:0] slot;

  i2s_slot_packer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i,
    .sck_rise_o(sck_rise), .ws_o(ws_s), .sd_o(sd_s)
  );

  i2s_slot_packer_slot_seq #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_seq (
    .clk_i, .rst_ni, .sck_rise_i(sck_rise), .ws_i(ws_s), .sd_i(sd_s),
    .byte_vld_o(byte_vld), .byte_o(byte_val), .slot_o(slot)
  );

  assign store = byte_vld & slot_en_i[slot];

  i2s_slot_packer_packer #(.BYTES(BYTES)) u_pack (
    .clk_i, .rst_ni, .store_i(store), .byte_i(byte_val), .swap_i, .fifo_rdy_i,
    .word_o, .word_valid_o, .overflow_o
  );
endmodule

// File: tb/i2s_slot_packer_tb.sv
`timescale 1ns/1ps
module i2s_slot_packer_tb_top;
  typedef struct packed {
    logic [17:0] r;
    logic [17:0] l;
    logic [7:0]  mask;
    logic        swap;
  } vec_t;

  // R1 R6: 0 | R7: 1 | R4: 2,5,6,7 | R5: 3,4 (word spans frames)
  localparam vec_t VECS [8] = '{
    '{18'h3A5C3, 18'h1B7E9, 8'hFF, 1'b0},
    '{18'h0F0F1, 18'h3C3C3, 8'hFF, 1'b1},
    '{18'h2D2D2, 18'h12345, 8'h33, 1'b0},
    '{18'h3FFFF, 18'h00001, 8'h03, 1'b1},
    '{18'h2468A, 18'h13579, 8'h03, 1'b1},
    '{18'h15555, 18'h2AAAA, 8'h81, 1'b0},
    '{18'h31111, 18'h0EEEE, 8'h81, 1'b0},
    '{18'h20000, 18'h1FFFF, 8'hF0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [7:0]  slot_en = 8'hFF;
  logic        swap = 1'b0, fifo_rdy = 1'b1;
  logic [31:0] word;
  logic        word_valid, overflow;

  always #4 clk = ~clk;

  i2s_slot_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .slot_en_i(slot_en), .swap_i(swap), .fifo_rdy_i(fifo_rdy),
    .word_o(word), .word_valid_o(word_valid), .overflow_o(overflow)
  );

  int          checks = 0, errors = 0;
  logic [31:0] exp_q [256];
  int          exp_cnt = 0, got_cnt = 0;
  logic [31:0] m_word = '0;
  int          m_place = 0;
  logic        m_ovf = 1'b0;
  logic        prev_valid = 1'b0;
  string       tag = "R6";
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    int lane = swap ? m_place : 3 - m_place;
    m_word[lane*8 +: 8] = b;
    if (m_place == 3) begin
      if (fifo_rdy) exp_q[exp_cnt++] = m_word;
      else m_ovf = 1'b1;
    end
    m_place = (m_place + 1) % 4;
  endtask

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    sck = 1'b0; ws = w; sd = d;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    sck = 1'b0; ws = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  // frame opens with a word-select rise; only fully sent slots count
  task automatic send_frame(input logic [17:0] r, input logic [17:0] l, input int nbits);
    logic [63:0] f = {r, 14'h0, l, 14'h0};
    for (int s = 0; s < 8; s++)
      if ((s + 1) * 8 <= nbits && slot_en[s]) model_byte(f[63 - 8*s -: 8]);
    for (int b = 0; b < nbits; b++) send_bit(b < 32, f[63 - b]);
    idle();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        check(!prev_valid, "R8", {31'h0, prev_valid}, 32'h0);
        if (got_cnt < exp_cnt) check(word == exp_q[got_cnt], tag, word, exp_q[got_cnt]);
        else check(1'b0, "R9", word, 32'h0);
        got_cnt++;
      end
      prev_valid <= word_valid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check(word_valid == 1'b0 && overflow == 1'b0, "R10", {30'h0, word_valid, overflow}, 32'h0);
    check(word == 32'h0, "R10", word, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(word_valid == 1'b0 && overflow == 1'b0 && word == 32'h0, "R10", word, 32'h0);

    // R3: data before any word-select rise is ignored
    for (int b = 0; b < 24; b++) send_bit(1'b0, b[0] ^ b[2]);
    idle();
    check(got_cnt == 0, "R3", 32'(got_cnt), 32'h0);

    foreach (VECS[i]) begin
      slot_en = VECS[i].mask;
      swap    = VECS[i].swap;
      tag = (VECS[i].mask == 8'h03) ? "R5" : (VECS[i].mask != 8'hFF) ? "R4" :
            VECS[i].swap ? "R7" : "R1 R6";
      send_frame(VECS[i].r, VECS[i].l, 64);
    end

    // R2: truncated frame, then a word-select rise restarts slot 0
    slot_en = 8'hFF; swap = 1'b0; tag = "R2";
    send_frame(18'h2C3A5, 18'h1E0F7, 40);
    send_frame(18'h05A5A, 18'h3A5A5, 64);

    // R9: stalled FIFO drops words and latches overflow
    fifo_rdy = 1'b0; tag = "R9";
    send_frame(18'h11111, 18'h22222, 64);
    check(overflow == 1'b1 && m_ovf, "R9", {31'h0, overflow}, 32'h1);
    fifo_rdy = 1'b1; swap = 1'b1;
    send_frame(18'h33333, 18'h04444, 64);
    check(overflow == 1'b1, "R9", {31'h0, overflow}, 32'h1);

    repeat (20) @(negedge clk);
    // R5: every word the pointer model predicts was delivered
    check(got_cnt == exp_cnt, "R5", 32'(got_cnt), 32'(exp_cnt));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", got_cnt, exp_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule